// File: doc/BRIEF.md
# Video Layer Fetch Start Controller

This block tells a display layer's memory DMA when to start fetching pixel data for the next field or frame. It also times a run of flush cycles that push the last real pixels out of the formatting pipeline. It runs in the pixel clock domain. The display timing generator supplies the current line number and an end-of-field strobe. A 32-bit control word selects between two fetch policies. In the first, the request is issued right away when a field ends (prefetch). In the second, the request waits until a programmed start line is reached.

In interlaced mode the programmed start line is read in field coordinates. The frame line counter is halved before the comparison, so a layer at frame line 100 is at field line 50. The block also checks the programmed start line against the layer's first active line. A start line that is not strictly earlier would starve the layer, and the block raises a configuration-error flag for it.

The control word, the mode flag and the layer's first line are all captured on the end-of-field strobe. A change written in the middle of a field only takes effect from the next field.

Top module: `vid_fetch_start_ctrl`

## Requirements
- R1: While the synchronous active-low reset is held, and at the first sample after it is released, fetch_req_o, flush_vld_o, flush_done_o and cfg_err_o are all 0.
- R2: When bit 31 of cfg_ctrl_i is 0 at the end-of-field cycle, fetch_req_o is 1 for exactly one cycle, and that cycle is the one right after the end-of-field cycle.
- R3: When bit 31 is 1 and interlaced_i is 0 at the end-of-field cycle, the request is delayed. fetch_req_o pulses in the cycle after the first later cycle in which line_i is at least the start line held in bits 11:0. It stays 0 before that.
- R4: When bit 31 is 1 and interlaced_i is 1 at the end-of-field cycle, the start line is compared against line_i shifted right by one. With a start line of 10, the first frame line that triggers the request is 20.
- R5: fetch_req_o pulses at most once between two end-of-field strobes. Each strobe re-arms it.
- R6: After an end-of-field cycle, flush_vld_o is 1 for exactly N consecutive cycles starting in the next cycle. N is the value of bits 27:16 of cfg_ctrl_i at that strobe.
- R7: flush_done_o pulses for one cycle in the cycle after the last flush-valid cycle. When N is 0, flush_vld_o stays 0 and flush_done_o pulses in the cycle right after the strobe.
- R8: A change to cfg_ctrl_i, interlaced_i or layer_y_i between strobes does not change fetch timing, flush length or cfg_err_o until the next strobe.
- R9: From the cycle after a strobe, cfg_err_o is 1 exactly when delayed fetch is enabled and the start line is not smaller than the layer's first line. In interlaced mode the layer's first line is layer_y_i shifted right by one. With a layer line of 100, a progressive start of 98 and an interlaced start of 48 are both legal, while interlaced starts of 50 and 52 are errors.
- R10: A reset asserted in the middle of a field cancels a pending delayed request and a running flush. No request or flush follows until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| line_i | input | 12 | Current frame line from the timing generator |
| eof_i | input | 1 | End-of-field strobe, one cycle |
| interlaced_i | input | 1 | 1 = interlaced output, 0 = progressive |
| cfg_ctrl_i | input | 32 | Control word: bit 31 delay enable, bits 27:16 flush count, bits 11:0 start line |
| layer_y_i | input | 12 | Layer's first active line, in frame coordinates |
| fetch_req_o | output | 1 | One-cycle request to start the DMA fetch |
| flush_vld_o | output | 1 | A flush pixel is being injected this cycle |
| flush_done_o | output | 1 | One-cycle pulse when the flush run is over |
| cfg_err_o | output | 1 | Start line is too late for the layer |

## Verification
The hardest case to reach is the interaction between the capture on the strobe and a delayed request that is still armed. The two ways this shows up are a configuration rewritten in the middle of a field and a reset that arrives while a request is pending. The stimulus arms a delayed request and then rewrites the control word to an earlier start line in the middle of the field, before sweeping the line counter. It then checks that the request still lands on the line captured at the strobe. A separate scenario starts a long flush together with a pending delayed request, applies reset partway through, and sweeps lines past the old start line to show that nothing remains.

// File: rtl/vfs_pkg.sv
package vfs_pkg;

   // Control word layout: these positions are decoded by software, so they are fixed.
   localparam int unsigned CTRL_W    = 32;
   localparam int unsigned DLY_BIT   = 31;
   localparam int unsigned FLUSH_LSB = 16;
   localparam int unsigned FLUSH_W   = 12;
   localparam int unsigned START_LSB = 0;
   localparam int unsigned START_W   = 12;

   localparam logic [FLUSH_W-1:0] FLUSH_RST = 12'h030;

   localparam logic [CTRL_W-1:0] USED_MASK =
      (32'h1 << DLY_BIT) |
      (((32'h1 << FLUSH_W) - 32'h1) << FLUSH_LSB) |
      (((32'h1 << START_W) - 32'h1) << START_LSB);

   typedef enum logic [1:0] {
      FS_IDLE  = 2'd0,
      FS_ARMED = 2'd1,
      FS_SPENT = 2'd2
   } fetch_state_e;

endpackage

// File: rtl/vfs_cfg_shadow.sv
module vfs_cfg_shadow
   import vfs_pkg::*;
#(
   parameter int unsigned LINE_W   = 12,
   parameter int unsigned CNT_W    = 12,
   parameter bit          ERR_CHECK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              eof_i,
   input  logic [CTRL_W-1:0] ctrl_i,
   input  logic              intl_i,
   input  logic [LINE_W-1:0] layer_y_i,
   output logic              nxt_dly_en_o,
   output logic [CNT_W-1:0]  nxt_flush_o,
   output logic              sh_dly_en_o,
   output logic              sh_intl_o,
   output logic [LINE_W-1:0] sh_start_o,
   output logic              cfg_err_o
);

   localparam logic [LINE_W-1:0] START_RST = '0;

   logic [START_W-1:0] start_fld;
   logic [FLUSH_W-1:0] flush_fld;
   logic               unused_ctrl_bits;

   logic               dly_q, intl_q;
   logic [LINE_W-1:0]  start_q, layer_q;

   assign start_fld        = ctrl_i[START_LSB +: START_W];
   assign flush_fld        = ctrl_i[FLUSH_LSB +: FLUSH_W];
   assign unused_ctrl_bits = ^(ctrl_i & ~USED_MASK);

   assign nxt_dly_en_o = ctrl_i[DLY_BIT];
   assign nxt_flush_o  = CNT_W'(flush_fld);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dly_q   <= 1'b0;
         intl_q  <= 1'b0;
         start_q <= START_RST;
         layer_q <= '0;
      end else if (eof_i) begin
         dly_q   <= ctrl_i[DLY_BIT];
         intl_q  <= intl_i;
         start_q <= LINE_W'(start_fld);
         layer_q <= layer_y_i;
      end
   end

   assign sh_dly_en_o = dly_q;
   assign sh_intl_o   = intl_q;
   assign sh_start_o  = start_q;

   generate
      if (ERR_CHECK) begin : g_err
         logic [LINE_W-1:0] layer_cmp;
         assign layer_cmp = intl_q ? (layer_q >> 1) : layer_q;
         assign cfg_err_o = dly_q && (start_q >= layer_cmp);
      end else begin : g_no_err
         assign cfg_err_o = 1'b0;
      end
   endgenerate

   // An error flag is only meaningful when the delayed policy is in force (R9)
   assert_err_needs_delay_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err_o |-> sh_dly_en_o);

endmodule

// File: rtl/vfs_fetch_trig.sv
module vfs_fetch_trig
   import vfs_pkg::*;
#(
   parameter int unsigned LINE_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              eof_i,
   input  logic              nxt_dly_en_i,
   input  logic              sh_intl_i,
   input  logic [LINE_W-1:0] sh_start_i,
   input  logic [LINE_W-1:0] line_i,
   output logic              fetch_req_o
);

   fetch_state_e      state_q;
   logic              req_q;
   logic [LINE_W-1:0] cmp_line;
   logic              reached;

   // Field coordinates in interlaced mode are half the frame line.
   assign cmp_line = sh_intl_i ? (line_i >> 1) : line_i;
   assign reached  = (cmp_line >= sh_start_i);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= FS_IDLE;
         req_q   <= 1'b0;
      end else if (eof_i) begin
         state_q <= nxt_dly_en_i ? FS_ARMED : FS_SPENT;
         req_q   <= !nxt_dly_en_i;
      end else if (state_q == FS_ARMED && reached) begin
         state_q <= FS_SPENT;
         req_q   <= 1'b1;
      end else begin
         req_q   <= 1'b0;
      end
   end

   assign fetch_req_o = req_q;

   // Independent tracker: has a request already gone out this field?
   logic fired_q;
   always_ff @(posedge clk) begin
      if (!rst_n)      fired_q <= 1'b0;
      else if (eof_i)  fired_q <= 1'b0;
      else if (req_q)  fired_q <= 1'b1;
   end

   assert_once_per_field_R5: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_req_o |-> !fired_q);

   // A request not caused by a strobe must follow a line at or past the start line (R3)
   assert_delay_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_req_o && !$past(eof_i)) |-> ($past(cmp_line) >= $past(sh_start_i)));

endmodule

// File: rtl/vfs_flush_ctr.sv
module vfs_flush_ctr #(
   parameter int unsigned CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             eof_i,
   input  logic [CNT_W-1:0] nxt_flush_i,
   output logic             flush_vld_o,
   output logic             flush_done_o
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] rem_q;
   logic             done_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rem_q  <= '0;
         done_q <= 1'b0;
      end else if (eof_i) begin
         rem_q  <= nxt_flush_i;
         done_q <= (nxt_flush_i == '0);
      end else begin
         if (rem_q != '0) rem_q <= rem_q - ONE;
         done_q <= (rem_q == ONE);
      end
   end

   assign flush_vld_o  = (rem_q != '0);
   assign flush_done_o = done_q;

   assert_flush_steps_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_vld_o && !eof_i) |=> (rem_q == $past(rem_q) - ONE));

   assert_done_after_vld_R7: assert property (@(posedge clk) disable iff (!rst_n)
      flush_done_o |-> !flush_vld_o);

   assert_zero_flush_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (eof_i && nxt_flush_i == '0) |=> (flush_done_o && !flush_vld_o));

endmodule

// File: rtl/vid_fetch_start_ctrl.sv
module vid_fetch_start_ctrl
   import vfs_pkg::*;
#(
   parameter int unsigned LINE_W    = 12,
   parameter int unsigned CNT_W     = 12,
   parameter bit          ERR_CHECK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LINE_W-1:0] line_i,
   input  logic              eof_i,
   input  logic              interlaced_i,
   input  logic [CTRL_W-1:0] cfg_ctrl_i,
   input  logic [LINE_W-1:0] layer_y_i,
   output logic              fetch_req_o,
   output logic              flush_vld_o,
   output logic              flush_done_o,
   output logic              cfg_err_o
);

   generate
      if (LINE_W < START_W) begin : g_bad_line_w
         $error("LINE_W must hold the full start-line field");
      end
      if (CNT_W < FLUSH_W) begin : g_bad_cnt_w
         $error("CNT_W must hold the full flush-count field");
      end
   endgenerate

   logic              nxt_dly_en;
   logic [CNT_W-1:0]  nxt_flush;
   logic              sh_dly_en, sh_intl;
   logic [LINE_W-1:0] sh_start;

   vfs_cfg_shadow #(
      .LINE_W   (LINE_W),
      .CNT_W    (CNT_W),
      .ERR_CHECK(ERR_CHECK)
   ) u_shadow (
      .clk         (clk),
      .rst_n       (rst_n),
      .eof_i       (eof_i),
      .ctrl_i      (cfg_ctrl_i),
      .intl_i      (interlaced_i),
      .layer_y_i   (layer_y_i),
      .nxt_dly_en_o(nxt_dly_en),
      .nxt_flush_o (nxt_flush),
      .sh_dly_en_o (sh_dly_en),
      .sh_intl_o   (sh_intl),
      .sh_start_o  (sh_start),
      .cfg_err_o   (cfg_err_o)
   );

   vfs_fetch_trig #(
      .LINE_W(LINE_W)
   ) u_fetch (
      .clk         (clk),
      .rst_n       (rst_n),
      .eof_i       (eof_i),
      .nxt_dly_en_i(nxt_dly_en),
      .sh_intl_i   (sh_intl),
      .sh_start_i  (sh_start),
      .line_i      (line_i),
      .fetch_req_o (fetch_req_o)
   );

   vfs_flush_ctr #(
      .CNT_W(CNT_W)
   ) u_flush (
      .clk         (clk),
      .rst_n       (rst_n),
      .eof_i       (eof_i),
      .nxt_flush_i (nxt_flush),
      .flush_vld_o (flush_vld_o),
      .flush_done_o(flush_done_o)
   );

   // A prefetch-policy strobe leads to a request on the next cycle (R2)
   assert_prefetch_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (eof_i && !cfg_ctrl_i[DLY_BIT]) |=> fetch_req_o);

endmodule

// File: tb/vid_fetch_start_ctrl_tb_top.sv
module vid_fetch_start_ctrl_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] line_i = '0;
   logic        eof_i = 1'b0;
   logic        interlaced_i = 1'b0;
   logic [31:0] cfg_ctrl_i = '0;
   logic [11:0] layer_y_i = '0;
   logic        fetch_req_o, flush_vld_o, flush_done_o, cfg_err_o;

   int n_tests = 0;
   int n_fail  = 0;

   always #10 clk = ~clk;

   vid_fetch_start_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .line_i(line_i), .eof_i(eof_i),
      .interlaced_i(interlaced_i), .cfg_ctrl_i(cfg_ctrl_i), .layer_y_i(layer_y_i),
      .fetch_req_o(fetch_req_o), .flush_vld_o(flush_vld_o),
      .flush_done_o(flush_done_o), .cfg_err_o(cfg_err_o)
   );

   function automatic logic [31:0] mk(input bit dly, input int flush, input int start);
      return {dly, 3'b000, 12'(flush), 4'b0000, 12'(start)};
   endfunction

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   // Drives a one-cycle strobe; returns at the negedge after the strobe's edge.
   task automatic strobe(input logic [31:0] ctrl, input bit intl, input int ly);
      cfg_ctrl_i   = ctrl;
      interlaced_i = intl;
      layer_y_i    = 12'(ly);
      line_i       = '0;
      eof_i        = 1'b1;
      tick();
      eof_i        = 1'b0;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      tick(); tick();
      chk("R1", "fetch in reset", fetch_req_o, 0);
      chk("R1", "flush_vld in reset", flush_vld_o, 0);
      rst_n = 1'b1;
      tick();
      chk("R1", "fetch after reset", fetch_req_o, 0);
      chk("R1", "flush_vld after reset", flush_vld_o, 0);
      chk("R1", "flush_done after reset", flush_done_o, 0);
      chk("R1", "cfg_err after reset", cfg_err_o, 0);
   endtask

   task automatic t_prefetch();
      int seen = 0;
      strobe(mk(0, 0, 0), 0, 100);
      chk("R2", "fetch right after strobe", fetch_req_o, 1);
      chk("R7", "zero flush: done after strobe", flush_done_o, 1);
      chk("R7", "zero flush: no valid", flush_vld_o, 0);
      tick();
      chk("R2", "fetch one cycle only", fetch_req_o, 0);
      for (int l = 1; l < 20; l++) begin
         line_i = 12'(l);
         tick();
         seen += fetch_req_o;
      end
      chk("R5", "no repeat fetch in field", seen, 0);
   endtask

   task automatic sweep_delay(input string req, input bit intl, input int start,
                              input int last, input int exp_line);
      int seen = 0;
      strobe(mk(1, 0, start), intl, 200);
      chk(req, "no fetch at strobe", fetch_req_o, 0);
      for (int l = 0; l <= last; l++) begin
         line_i = 12'(l);
         tick();
         chk(req, $sformatf("fetch at line %0d", l), fetch_req_o, (l == exp_line) ? 1 : 0);
         seen += fetch_req_o;
      end
      chk("R5", "single delayed fetch", seen, 1);
   endtask

   task automatic t_delay_prog();
      sweep_delay("R3", 0, 10, 15, 10);
   endtask

   task automatic t_delay_intl();
      sweep_delay("R4", 1, 10, 25, 20);
   endtask

   task automatic t_flush();
      strobe(mk(0, 5, 0), 0, 100);
      for (int i = 0; i < 8; i++) begin
         chk("R6", $sformatf("flush_vld cycle %0d", i), flush_vld_o, (i < 5) ? 1 : 0);
         chk("R7", $sformatf("flush_done cycle %0d", i), flush_done_o, (i == 5) ? 1 : 0);
         tick();
      end
   endtask

   task automatic t_midfield();
      int fl = 0;
      strobe(mk(1, 3, 10), 0, 200);
      cfg_ctrl_i   = mk(1, 9, 2);
      interlaced_i = 1'b1;
      layer_y_i    = 12'd4;
      for (int l = 0; l <= 12; l++) begin
         fl += flush_vld_o;
         line_i = 12'(l);
         tick();
         chk("R8", $sformatf("fetch at line %0d after rewrite", l), fetch_req_o,
             (l == 10) ? 1 : 0);
      end
      chk("R8", "flush length kept", fl, 3);
      chk("R8", "cfg_err kept", cfg_err_o, 0);
   endtask

   task automatic t_cfg_err();
      strobe(mk(1, 0, 98), 0, 100);
      chk("R9", "prog start 98 vs 100", cfg_err_o, 0);
      strobe(mk(1, 0, 100), 0, 100);
      chk("R9", "prog start 100 vs 100", cfg_err_o, 1);
      strobe(mk(1, 0, 48), 1, 100);
      chk("R9", "intl start 48 vs 100", cfg_err_o, 0);
      strobe(mk(1, 0, 50), 1, 100);
      chk("R9", "intl start 50 vs 100", cfg_err_o, 1);
      strobe(mk(1, 0, 52), 1, 100);
      chk("R9", "intl start 52 vs 100", cfg_err_o, 1);
      strobe(mk(0, 0, 200), 0, 100);
      chk("R9", "prefetch never errors", cfg_err_o, 0);
      tick();
   endtask

   task automatic t_reset_mid();
      int f = 0, v = 0;
      strobe(mk(1, 20, 5), 0, 100);
      tick(); tick();
      rst_n = 1'b0;
      tick();
      chk("R10", "flush cut by reset", flush_vld_o, 0);
      rst_n = 1'b1;
      for (int l = 0; l <= 30; l++) begin
         line_i = 12'(l);
         tick();
         f += fetch_req_o;
         v += flush_vld_o;
      end
      chk("R10", "no fetch after reset", f, 0);
      chk("R10", "no flush after reset", v, 0);
   endtask

   initial begin
      #4_000_000;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      tick();
      t_reset();
      t_prefetch();
      t_delay_prog();
      t_delay_intl();
      t_flush();
      t_midfield();
      t_cfg_err();
      t_reset_mid();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule